// File: doc/BRIEF.md
# Register-Mapped Port Expander with Interrupt Aggregation

This block sits next to a host processor on a simple synchronous register bus. It gives the host a bank of input pins and a bank of output pins. It also gathers up to sixteen interrupt sources into one interrupt line. The host sees a small set of word registers. Their byte addresses are the register index scaled by the bus width, which is 16 or 32 bits. Each register holds 8 or 16 pin bits.

A rising edge on any interrupt source sets that source's pending bit. The hardware has no mask, so every edge is latched. The host reads the pending bits from a status register. It clears all of them by writing a fixed acknowledge word to the same address. The interrupt line is a registered level that the host detects on its rising edge. After an acknowledge, the line always drops for a cycle, so an event that arrives during the acknowledge produces a new edge.

Output registers come out of reset with a parameterised pattern. They keep driving the pins until the host rewrites them.

Top module: `gpx_expander`

## Requirements
- R1: The register index is the byte address shifted right by 1 when BUS_W is 16, or by 2 when BUS_W is 32. The low address bits below that shift are ignored.
- R2: Input pin n passes through a two-flop synchronizer. It reads back at bit n mod REG_W of register IN_BASE + n / REG_W. Read data appears on bus_rdata one clock after the read strobe is sampled, and it holds until the next read.
- R3: A write to register OUT_BASE + k replaces every output pin it covers. Pin n takes write-data bit n mod REG_W, with k = n / REG_W. The new value drives the pins from the clock edge that samples the write. A read of that register returns the driven pin values, zero-extended.
- R4: After reset, out_pins equal OUT_INIT, irq_out is 0, no bit is pending, and bus_rdata is 0.
- R5: A rising edge on synchronized source i sets pending bit i. There is no mask. A source that is held high does not set the bit again. Register STAT_IDX reads the pending bits, with source i at bit i.
- R6: Writing the acknowledge word to STAT_IDX clears all pending bits. The word is 16'hFFFF, or 16'h0000 when ACK_INVERT is set. Any other value written there has no effect.
- R7: irq_out is registered. It goes high on the same edge at which pending becomes non-zero, which is three clock edges after a source pin rises. It stays high while any bit is pending.
- R8: A source edge sampled in the same cycle as an acknowledge keeps its pending bit. In that case irq_out is low for exactly one cycle after the acknowledge and then rises again.
- R9: A read of an unmapped index returns 0. A write to an unmapped index or to an input register changes nothing.
- R10: Output pins keep their value in every cycle without a write to their register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| in_pins | input | N_IN | Asynchronous input pins |
| out_pins | output | N_OUT | Output pins |
| irq_src | input | N_IRQ | Asynchronous interrupt sources |
| irq_out | output | 1 | Interrupt line to the host |

## Verification
Each result has a fixed latency:
- A write shows on out_pins right after the clock edge that samples the strobe.
- Read data is valid right after the edge that samples the read strobe.
- A source edge raises irq_out on the third edge after the pin changes.
- An acknowledge forces irq_out low for exactly the following cycle.

The bench drives and samples only on falling edges, so every comparison lands on a known cycle. The interrupt latency is checked one cycle before the edge, where the line must still be low, and at the edge itself. The acknowledge race is lined up so that the source edge and the acknowledge write are sampled on the same clock edge. A second instance, with a 32-bit bus, 16-bit registers and an inverted acknowledge word, covers the other address scaling and acknowledge encoding.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  // byte-to-index shift for the host bus width
  function automatic int bus_shift(input int bus_w);
    return (bus_w == 32) ? 2 : 1;
  endfunction

  // number of registers needed to hold n pins of width w
  function automatic int reg_count(input int n, input int w);
    return (n + w - 1) / w;
  endfunction

  function automatic logic [15:0] ack_word(input bit inverted);
    return inverted ? 16'h0000 : 16'hFFFF;
  endfunction
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stg1_q;
  logic [W-1:0] stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= d_async;
      stg2_q <= stg1_q;
    end
  end

  assign d_sync = stg2_q;
endmodule

// File: rtl/gpx_pend.sv
module gpx_pend #(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] src_s,
  input  logic             ack,
  output logic [N_IRQ-1:0] pend,
  output logic             irq
);
  logic [N_IRQ-1:0] src_d_q;
  logic [N_IRQ-1:0] pend_q, pend_nxt;
  logic [N_IRQ-1:0] rise;
  logic             irq_q, irq_nxt;

  always_comb begin
    rise     = src_s & ~src_d_q;
    pend_nxt = (ack ? '0 : pend_q) | rise;
    irq_nxt  = (|pend_nxt) & ~ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_d_q <= '0;
      pend_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      src_d_q <= src_s;
      pend_q  <= pend_nxt;
      irq_q   <= irq_nxt;
    end
  end

  assign pend = pend_q;
  assign irq  = irq_q;

  // R5: an edge always lands in the pending register
  a_r5_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));
  // R6: an acknowledge without a new edge leaves nothing pending
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !(|rise)) |=> (pend_q == '0));
  // R8: the line is always low in the cycle after an acknowledge
  a_r8_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !irq_q);
  // R7: a raised line always has a pending cause
  a_r7_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (pend_q != '0));
endmodule

// File: rtl/gpx_outbank.sv
module gpx_outbank #(
  parameter int               REG_W  = 8,
  parameter int               N_OUT  = 12,
  parameter int               N_REGS = 2,
  parameter logic [N_OUT-1:0] INIT   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_REGS-1:0] wr_en,
  input  logic [REG_W-1:0]  wdata,
  output logic [N_OUT-1:0]  q
);
  logic [N_OUT-1:0] q_nxt;
  logic             unused_wd;

  assign unused_wd = ^wdata;

  for (genvar n = 0; n < N_OUT; n++) begin : g_pin
    localparam int K = n / REG_W;
    localparam int J = n % REG_W;

    always_comb q_nxt[n] = wr_en[K] ? wdata[J] : q[n];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[n] <= INIT[n];
      else        q[n] <= q_nxt[n];
    end
  end

  // R10: pins hold when their registers are not written
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(|wr_en) |=> $stable(q));
endmodule

// File: rtl/gpx_regif.sv
module gpx_regif
  import gpx_pkg::*;
#(
  parameter int BUS_W      = 16,
  parameter int REG_W      = 8,
  parameter int ADDR_W     = 8,
  parameter int N_IN       = 12,
  parameter int N_OUT      = 12,
  parameter int N_IRQ      = 8,
  parameter int IN_BASE    = 0,
  parameter int OUT_BASE   = 4,
  parameter int STAT_IDX   = 7,
  parameter bit ACK_INVERT = 1'b0,
  localparam int BSH        = bus_shift(BUS_W),
  localparam int IDX_W      = ADDR_W - BSH,
  localparam int N_OUT_REGS = reg_count(N_OUT, REG_W)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_rd,
  input  logic                  bus_wr,
  input  logic [15:0]           bus_wdata,
  output logic [15:0]           bus_rdata,
  input  logic [N_IN-1:0]       in_s,
  input  logic [N_OUT-1:0]      out_q,
  input  logic [N_IRQ-1:0]      pend,
  output logic [N_OUT_REGS-1:0] wr_en,
  output logic                  ack
);
  localparam logic [15:0] ACK_VAL = ack_word(ACK_INVERT);

  logic [IDX_W-1:0] idx;
  logic             unused_lo;
  logic [15:0]      rd_val;
  logic             hit;
  logic [15:0]      rdata_q, rdata_nxt;

  assign idx       = bus_addr[ADDR_W-1:BSH];
  assign unused_lo = ^bus_addr[BSH-1:0];

  for (genvar k = 0; k < N_OUT_REGS; k++) begin : g_wen
    assign wr_en[k] = bus_wr && (idx == IDX_W'(OUT_BASE + k));
  end

  assign ack = bus_wr && (idx == IDX_W'(STAT_IDX)) && (bus_wdata == ACK_VAL);

  always_comb begin
    rd_val = '0;
    hit    = 1'b0;
    for (int n = 0; n < N_IN; n++) begin
      if (idx == IDX_W'(IN_BASE + n / REG_W)) begin
        rd_val[n % REG_W] = in_s[n];
        hit               = 1'b1;
      end
    end
    for (int n = 0; n < N_OUT; n++) begin
      if (idx == IDX_W'(OUT_BASE + n / REG_W)) begin
        rd_val[n % REG_W] = out_q[n];
        hit               = 1'b1;
      end
    end
    if (idx == IDX_W'(STAT_IDX)) begin
      rd_val[N_IRQ-1:0] = pend;
      hit               = 1'b1;
    end
  end

  always_comb rdata_nxt = bus_rd ? rd_val : rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_nxt;
  end

  assign bus_rdata = rdata_q;

  // R9: unmapped reads return zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !hit) |=> (bus_rdata == 16'h0000));
  // R2: read data holds between strobes
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
  // R6: acknowledge and output write never coincide
  a_r6_ack_excl: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !(|wr_en));
endmodule

// File: rtl/gpx_expander.sv
module gpx_expander
  import gpx_pkg::*;
#(
  parameter int               BUS_W      = 16,
  parameter int               REG_W      = 8,
  parameter int               ADDR_W     = 8,
  parameter int               N_IN       = 12,
  parameter int               N_OUT      = 12,
  parameter int               N_IRQ      = 8,
  parameter int               IN_BASE    = 0,
  parameter int               OUT_BASE   = 4,
  parameter int               STAT_IDX   = 7,
  parameter bit               ACK_INVERT = 1'b0,
  parameter logic [N_OUT-1:0] OUT_INIT   = 12'h5A3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic [N_IN-1:0]   in_pins,
  output logic [N_OUT-1:0]  out_pins,
  input  logic [N_IRQ-1:0]  irq_src,
  output logic              irq_out
);
  localparam int N_OUT_REGS = reg_count(N_OUT, REG_W);

  logic [1:0]            rst_sync_q;
  logic                  rst_int_n;
  logic [N_IN-1:0]       in_s;
  logic [N_IRQ-1:0]      src_s;
  logic [N_IRQ-1:0]      pend;
  logic [N_OUT_REGS-1:0] wr_en;
  logic                  ack;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  gpx_sync #(.W(N_IN)) u_in_sync (
    .clk(clk), .rst_n(rst_int_n), .d_async(in_pins), .d_sync(in_s)
  );

  gpx_sync #(.W(N_IRQ)) u_src_sync (
    .clk(clk), .rst_n(rst_int_n), .d_async(irq_src), .d_sync(src_s)
  );

  gpx_regif #(
    .BUS_W(BUS_W), .REG_W(REG_W), .ADDR_W(ADDR_W), .N_IN(N_IN),
    .N_OUT(N_OUT), .N_IRQ(N_IRQ), .IN_BASE(IN_BASE), .OUT_BASE(OUT_BASE),
    .STAT_IDX(STAT_IDX), .ACK_INVERT(ACK_INVERT)
  ) u_regif (
    .clk(clk), .rst_n(rst_int_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .in_s(in_s), .out_q(out_pins), .pend(pend), .wr_en(wr_en), .ack(ack)
  );

  gpx_outbank #(
    .REG_W(REG_W), .N_OUT(N_OUT), .N_REGS(N_OUT_REGS), .INIT(OUT_INIT)
  ) u_outbank (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en),
    .wdata(bus_wdata[REG_W-1:0]), .q(out_pins)
  );

  gpx_pend #(.N_IRQ(N_IRQ)) u_pend (
    .clk(clk), .rst_n(rst_int_n), .src_s(src_s), .ack(ack),
    .pend(pend), .irq(irq_out)
  );
endmodule

// File: tb/gpx_expander_tb.sv
module gpx_expander_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  a_addr = '0, b_addr = '0;
  logic        a_rd = 1'b0, a_wr = 1'b0, b_rd = 1'b0, b_wr = 1'b0;
  logic [15:0] a_wd = '0, b_wd = '0;
  logic [15:0] a_rdata, b_rdata;
  logic [11:0] in_pins = '0;
  logic [11:0] a_out, b_out;
  logic [15:0] irq_src = '0;
  logic        a_irq, b_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  gpx_expander u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(a_addr), .bus_rd(a_rd), .bus_wr(a_wr),
    .bus_wdata(a_wd), .bus_rdata(a_rdata), .in_pins(in_pins), .out_pins(a_out),
    .irq_src(irq_src[7:0]), .irq_out(a_irq)
  );

  gpx_expander #(
    .BUS_W(32), .REG_W(16), .N_IRQ(16), .ACK_INVERT(1'b1), .OUT_INIT(12'h0F0)
  ) u_dut32 (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_rd(b_rd), .bus_wr(b_wr),
    .bus_wdata(b_wd), .bus_rdata(b_rdata), .in_pins(in_pins), .out_pins(b_out),
    .irq_src(irq_src), .irq_out(b_irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // caller is at a falling edge; returns at the next falling edge
  task automatic bwr(input bit sel, input logic [7:0] ad, input logic [15:0] d);
    if (!sel) begin a_addr = ad; a_wd = d; a_wr = 1'b1; end
    else      begin b_addr = ad; b_wd = d; b_wr = 1'b1; end
    @(negedge clk);
    a_wr = 1'b0; b_wr = 1'b0;
  endtask

  task automatic brd(input bit sel, input logic [7:0] ad, output logic [15:0] d);
    if (!sel) begin a_addr = ad; a_rd = 1'b1; end
    else      begin b_addr = ad; b_rd = 1'b1; end
    @(negedge clk);
    a_rd = 1'b0; b_rd = 1'b0;
    d = sel ? b_rdata : a_rdata;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R4 out_pins a", {4'h0, a_out}, 16'h05A3);
    chk("R4 out_pins b", {4'h0, b_out}, 16'h00F0);
    chk("R4 irq a", {15'h0, a_irq}, 16'h0);
    chk("R4 rdata a", a_rdata, 16'h0);
    chk("R4 rdata b", b_rdata, 16'h0);
  endtask

  task automatic t_outputs;
    logic [15:0] d;
    bwr(0, 8'h08, 16'hAB3C);
    chk("R3 low reg write", {4'h0, a_out}, 16'h053C);
    bwr(0, 8'h0B, 16'hFFFF);            // R1: low byte bit ignored
    chk("R3 R1 high reg write", {4'h0, a_out}, 16'h0F3C);
    brd(0, 8'h0A, d);
    chk("R3 readback masked", d, 16'h000F);
    brd(0, 8'h09, d);
    chk("R3 readback low", d, 16'h003C);
    bwr(1, 8'h13, 16'hABCD);            // R1: 32-bit bus ignores two bits
    chk("R3 R1 wide write", {4'h0, b_out}, 16'h0BCD);
    brd(1, 8'h10, d);
    chk("R3 wide readback", d, 16'h0BCD);
  endtask

  task automatic t_inputs;
    logic [15:0] d;
    in_pins = 12'hA5C;
    wait_n(3);
    brd(0, 8'h00, d);
    chk("R2 input low reg", d, 16'h005C);
    brd(0, 8'h03, d);
    chk("R2 R1 input high reg", d, 16'h000A);
    in_pins = 12'h000;
    wait_n(3);
    chk("R2 rdata held", d, a_rdata);
    brd(1, 8'h02, d);
    chk("R2 R1 wide input", d, 16'h0000);
    in_pins = 12'hA5C;
    wait_n(3);
    brd(1, 8'h01, d);
    chk("R2 wide input value", d, 16'h0A5C);
  endtask

  task automatic t_unmapped;
    logic [15:0] d;
    brd(0, 8'h00, d);
    brd(0, 8'h06, d);
    chk("R9 unmapped read", d, 16'h0000);
    bwr(0, 8'h0C, 16'h0000);
    chk("R9 unmapped write", {4'h0, a_out}, 16'h0F3C);
    bwr(0, 8'h00, 16'h00FF);
    brd(0, 8'h00, d);
    chk("R9 input write ignored", d, 16'h005C);
  endtask

  task automatic t_irq;
    logic [15:0] d;
    irq_src[2] = 1'b1;
    wait_n(2);
    chk("R7 irq not yet", {15'h0, a_irq}, 16'h0);
    wait_n(1);
    chk("R7 irq on third edge", {15'h0, a_irq}, 16'h1);
    brd(0, 8'h0E, d);
    chk("R5 status bit2", d, 16'h0004);
    irq_src[2] = 1'b0;
    wait_n(3);
    bwr(0, 8'h0E, 16'h1234);
    brd(0, 8'h0E, d);
    chk("R6 wrong word ignored", d, 16'h0004);
    chk("R7 irq stays high", {15'h0, a_irq}, 16'h1);
    bwr(0, 8'h0E, 16'hFFFF);
    chk("R6 irq low after ack", {15'h0, a_irq}, 16'h0);
    brd(0, 8'h0E, d);
    chk("R6 status cleared", d, 16'h0000);
    irq_src[3] = 1'b1;
    wait_n(3);
    chk("R7 irq src3", {15'h0, a_irq}, 16'h1);
    bwr(0, 8'h0E, 16'hFFFF);
    wait_n(4);
    chk("R5 level no retrigger irq", {15'h0, a_irq}, 16'h0);
    brd(0, 8'h0E, d);
    chk("R5 level no retrigger", d, 16'h0000);
  endtask

  task automatic t_race;
    logic [15:0] d;
    irq_src[1] = 1'b1;
    wait_n(3);
    chk("R7 irq src1", {15'h0, a_irq}, 16'h1);
    irq_src[5] = 1'b1;
    wait_n(2);
    bwr(0, 8'h0E, 16'hFFFF);            // sampled with the src5 edge
    chk("R8 drop cycle", {15'h0, a_irq}, 16'h0);
    wait_n(1);
    chk("R8 fresh edge", {15'h0, a_irq}, 16'h1);
    brd(0, 8'h0E, d);
    chk("R8 kept bit5", d, 16'h0020);
  endtask

  task automatic t_inverted_ack;
    logic [15:0] d;
    brd(1, 8'h1C, d);
    chk("R5 wide status", d, 16'h002E);
    bwr(1, 8'h1C, 16'hFFFF);
    brd(1, 8'h1C, d);
    chk("R6 ones not ack when inverted", d, 16'h002E);
    chk("R7 wide irq high", {15'h0, b_irq}, 16'h1);
    bwr(1, 8'h1E, 16'h0000);            // R1: low bits ignored
    chk("R6 inverted ack irq", {15'h0, b_irq}, 16'h0);
    brd(1, 8'h1C, d);
    chk("R6 inverted ack clears", d, 16'h0000);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(4);
    t_reset();
    t_outputs();
    t_inputs();
    t_unmapped();
    t_irq();
    t_race();
    t_inverted_ack();
    summary();
  end
endmodule